// File: doc/BRIEF.md
# Grouped Block Protection Manager

This block stands between the command logic of a byte-wide flash array and the program/erase engine. The array has sixteen uniform 64 KB erase blocks, and the top four bits of a 20-bit address name the block. Protection is not held for each block. Two neighbouring blocks share one protection group, which gives eight groups with one stored protect bit each. Each program, single-block erase or multi-block erase request is checked against these bits. The result is a one-cycle grant or deny pulse and a per-block grant mask that the engine uses to decide which blocks it may touch.

Group protect bits are set and cleared with explicit commands that name a group. A temporary-unprotect level input lifts all protection while it is held high. The stored bits are not altered by it, so protection comes back as soon as the level drops. Only the power-on reset clears the protect bits. The hardware-reset input clears the pending result and nothing else.

Top module: `bprot_top`

## Requirements
- R1: The reported block index equals address bits 19..16 of the request. It appears on `blk_idx` one cycle after the strobe and holds until the next request.
- R2: Block b belongs to group b>>1. Setting or clearing a group's bit affects both blocks of that pair and no other block.
- R3: With `temp_unprot` low, a program (op 2'b00) or single-block erase (op 2'b01) request to a protected block gives `deny`=1, `grant`=0 and `grant_mask`=0 one cycle after the strobe.
- R4: A program or single-block erase to an unprotected block gives `grant`=1, `deny`=0, and a `grant_mask` with only bit b set.
- R5: While `temp_unprot` is high at the strobe, every block is granted whatever its group bit.
- R6: Raising and lowering `temp_unprot` leaves the stored bits unchanged. Protected blocks are denied again once it is low.
- R7: `grant` and `deny` are single-cycle pulses in the cycle after a strobe. In a cycle that follows no strobe, `grant`, `deny` and `grant_mask` are 0.
- R8: A multi-block erase (op[1]=1) uses `erase_mask` bit b for block b. The result is `grant_mask` = mask AND allowed, `grant` = any granted bit, and `deny` = any masked block refused. An empty mask gives neither grant nor deny.
- R9: A set and a clear command for the same group in the same cycle leave the group protected. A command reaches only requests strobed in a later cycle.
- R10: With `rst_n` low at a clock edge, all protect bits are cleared and all outputs are zeroed. With `hwrst_n` low at an edge, the outputs are zeroed and any strobe in that cycle is dropped, but the protect bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| hwrst_n | input | 1 | Hardware reset, synchronous, active low; keeps protect bits |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 program, 01 block erase, 1x multi-block erase |
| req_addr | input | 20 | Target byte address |
| erase_mask | input | 16 | Block mask for multi-block erase |
| prot_set | input | 1 | Set protect bit of group `prot_grp` |
| prot_clr | input | 1 | Clear protect bit of group `prot_grp` |
| prot_grp | input | 3 | Group addressed by set/clear |
| temp_unprot | input | 1 | Level that lifts all protection |
| grant | output | 1 | Request (or part of it) allowed |
| deny | output | 1 | Request (or part of it) refused |
| grant_mask | output | 16 | Blocks the engine may modify |
| blk_idx | output | 4 | Block decoded from the last request address |

## Verification
The hardest case to reach is a stored bit that must survive a temporary-unprotect window and then bite again, and must also survive a hardware reset. Random traffic seldom lines up a protect, a raised level, a release and a request to the same pair. Directed sequences therefore protect one group, request both of its blocks and a neighbour across the level and a hardware-reset pulse, and then clear the group. Random phases mix set/clear collisions and multi-block masks against a bench model of the eight bits.

// File: rtl/bprot_pkg.sv
// Package bprot_pkg
// Shared request-type encoding for the grouped block protection manager.
// Assumes that op bit 1 alone marks a multi-block erase.
package bprot_pkg;
    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_BERASE = 2'b01,
        OP_MERASE = 2'b10,
        OP_MERASE2 = 2'b11
    } bprot_op_e;

    function automatic logic is_multi(input logic [1:0] op);
        return op[1];
    endfunction
endpackage

// File: rtl/bprot_blk_decode.sv
// Module bprot_blk_decode
// Extracts the block index from the top address bits and gives a one-hot form.
// Assumes uniform blocks whose size is a power of two.
module bprot_blk_decode #(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BLK_W-1:0]  blk,
    output logic [NBLK-1:0]   blk_onehot
);
    // Take the block field and expand it to one-hot.
    always_comb begin
        blk        = addr[ADDR_W-1 -: BLK_W];
        blk_onehot = '0;
        blk_onehot[blk] = 1'b1;
    end
endmodule

// File: rtl/bprot_store.sv
// Module bprot_store
// Holds one protect bit per group. Set wins over clear in the same cycle.
// Assumes rst_n is the power-on reset; no other reset touches these bits.
module bprot_store #(
    parameter int NGRP  = 8,
    localparam int GRP_W = $clog2(NGRP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_cmd,
    input  logic             clr_cmd,
    input  logic [GRP_W-1:0] grp,
    output logic [NGRP-1:0]  prot_q
);
    // Update the addressed group bit on set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
        end else if (set_cmd) begin
            prot_q[grp] <= 1'b1;
        end else if (clr_cmd) begin
            prot_q[grp] <= 1'b0;
        end
    end
endmodule

// File: rtl/bprot_grant_eval.sv
// Module bprot_grant_eval
// Works out for each block whether modification is allowed and masks the request.
// Assumes groups are formed of 2**GRP_SHIFT adjacent blocks.
module bprot_grant_eval #(
    parameter int BLK_W     = 4,
    parameter int GRP_SHIFT = 1,
    localparam int NBLK     = 1 << BLK_W,
    localparam int NGRP     = NBLK >> GRP_SHIFT
) (
    input  logic [NGRP-1:0] prot_q,
    input  logic            temp_unprot,
    input  logic [NBLK-1:0] req_mask,
    output logic [NBLK-1:0] gmask
);
    logic [NBLK-1:0] allowed;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        // A block is allowed when its group is clear or protection is lifted.
        always_comb allowed[b] = temp_unprot | ~prot_q[b >> GRP_SHIFT];
    end

    // Keep only the requested blocks that are allowed.
    always_comb gmask = req_mask & allowed;
endmodule

// File: rtl/bprot_top.sv
// Module bprot_top
// Grouped block protection manager: decodes the request target, checks it
// against per-group protect bits, and registers a one-cycle grant/deny.
// Assumes requests and protect commands are synchronous to clk.
module bprot_top #(
    parameter int ADDR_W    = 20,
    parameter int BLK_W     = 4,
    parameter int GRP_SHIFT = 1,
    localparam int NBLK     = 1 << BLK_W,
    localparam int NGRP     = NBLK >> GRP_SHIFT,
    localparam int GRP_W    = BLK_W - GRP_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hwrst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NBLK-1:0]   erase_mask,
    input  logic              prot_set,
    input  logic              prot_clr,
    input  logic [GRP_W-1:0]  prot_grp,
    input  logic              temp_unprot,
    output logic              grant,
    output logic              deny,
    output logic [NBLK-1:0]   grant_mask,
    output logic [BLK_W-1:0]  blk_idx
);
    import bprot_pkg::*;

    logic [BLK_W-1:0] blk;
    logic [NBLK-1:0]  blk_onehot;
    logic [NBLK-1:0]  req_mask;
    logic [NBLK-1:0]  gmask;
    logic [NGRP-1:0]  prot_q;

    bprot_blk_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .addr       (req_addr),
        .blk        (blk),
        .blk_onehot (blk_onehot)
    );

    bprot_store #(.NGRP(NGRP)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (prot_set),
        .clr_cmd (prot_clr),
        .grp     (prot_grp),
        .prot_q  (prot_q)
    );

    // Pick the blocks a request targets from its type.
    always_comb req_mask = is_multi(req_op) ? erase_mask : blk_onehot;

    bprot_grant_eval #(.BLK_W(BLK_W), .GRP_SHIFT(GRP_SHIFT)) u_eval (
        .prot_q      (prot_q),
        .temp_unprot (temp_unprot),
        .req_mask    (req_mask),
        .gmask       (gmask)
    );

    // Register the decision as a single-cycle pulse; hold the block index.
    always_ff @(posedge clk) begin
        if (!rst_n || !hwrst_n) begin
            grant      <= 1'b0;
            deny       <= 1'b0;
            grant_mask <= '0;
            if (!rst_n) blk_idx <= '0;
        end else if (req_valid) begin
            grant      <= |gmask;
            deny       <= |(req_mask & ~gmask);
            grant_mask <= gmask;
            blk_idx    <= blk;
        end else begin
            grant      <= 1'b0;
            deny       <= 1'b0;
            grant_mask <= '0;
        end
    end
endmodule

// File: rtl/bprot_checker.sv
// Module bprot_checker
// Temporal checks on the protection manager, attached with bind.
module bprot_checker #(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4,
    parameter int NGRP   = 8,
    localparam int NBLK  = 1 << BLK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hwrst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              prot_set,
    input logic              prot_clr,
    input logic              temp_unprot,
    input logic              grant,
    input logic              deny,
    input logic [NBLK-1:0]   grant_mask,
    input logic [BLK_W-1:0]  blk_idx,
    input logic [NGRP-1:0]   prot_q
);
    // R1: the index follows the address of the last accepted request.
    assert_blk_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && hwrst_n) |-> blk_idx == $past(req_addr[ADDR_W-1 -: BLK_W]));

    // R5: no denial while protection is lifted.
    assert_temp_no_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && temp_unprot) |-> !deny);

    // R7: quiet outputs after a cycle without a request.
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!grant && !deny && grant_mask == '0));

    // R4: a single-block grant names exactly one block.
    assert_single_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_op[1]) |-> ($countones(grant_mask) == (grant ? 1 : 0)) && !(grant && deny));

    // R6: stored bits move only on a set or clear command.
    assert_bits_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!prot_set && !prot_clr) |-> $stable(prot_q));

    // R10: a hardware reset zeroes the result.
    assert_hwrst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hwrst_n) |-> (!grant && !deny));
endmodule

bind bprot_top bprot_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .NGRP(NGRP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hwrst_n     (hwrst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .prot_set    (prot_set),
    .prot_clr    (prot_clr),
    .temp_unprot (temp_unprot),
    .grant       (grant),
    .deny        (deny),
    .grant_mask  (grant_mask),
    .blk_idx     (blk_idx),
    .prot_q      (prot_q)
);

// File: tb/tb_bprot_top.sv
module tb_bprot_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, hwrst_n, req_valid, prot_set, prot_clr, temp_unprot;
    logic [1:0]  req_op;
    logic [19:0] req_addr;
    logic [15:0] erase_mask;
    logic [2:0]  prot_grp;
    logic        grant, deny;
    logic [15:0] grant_mask;
    logic [3:0]  blk_idx;

    int checks = 0;
    int failures = 0;
    logic [7:0]  m_prot = '0;
    logic [3:0]  m_idx = '0;
    logic        done = 1'b0;

    bprot_top dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] f_req(input logic [1:0] op, input logic [19:0] a,
                                          input logic [15:0] m);
        return op[1] ? m : (16'h1 << a[19:16]);
    endfunction

    function automatic logic [15:0] f_gm(input logic [7:0] p, input logic t,
                                         input logic [15:0] rq);
        logic [15:0] al;
        for (int b = 0; b < 16; b++) al[b] = t | ~p[b/2];
        return rq & al;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, compute expectation from pre-edge model, check after edge.
    task automatic step(input string tag, input logic v, input logic [1:0] op,
                        input logic [19:0] a, input logic [15:0] m,
                        input logic s, input logic c, input logic [2:0] g,
                        input logic t, input logic hr);
        logic [15:0] rq, gm;
        logic eg, ed;
        @(negedge clk);
        req_valid = v; req_op = op; req_addr = a; erase_mask = m;
        prot_set = s; prot_clr = c; prot_grp = g; temp_unprot = t; hwrst_n = hr;
        rq = f_req(op, a, m);
        gm = (v && hr) ? f_gm(m_prot, t, rq) : 16'h0;
        eg = |gm;
        ed = (v && hr) ? |(rq & ~gm) : 1'b0;
        if (v && hr) m_idx = a[19:16];
        @(posedge clk); #1;
        check({tag, " grant"}, {31'd0, grant}, {31'd0, eg});
        check({tag, " deny"}, {31'd0, deny}, {31'd0, ed});
        check({tag, " mask"}, {16'd0, grant_mask}, {16'd0, gm});
        check({tag, " idx"}, {28'd0, blk_idx}, {28'd0, m_idx});
        if (s) m_prot[g] = 1'b1;
        else if (c) m_prot[g] = 1'b0;
    endtask

    task automatic req(input string tag, input logic [1:0] op, input logic [3:0] b,
                       input logic [15:0] m, input logic t);
        step(tag, 1'b1, op, {b, 16'h1234}, m, 1'b0, 1'b0, 3'd0, t, 1'b1);
    endtask

    task automatic cmd(input string tag, input logic s, input logic c, input logic [2:0] g);
        step(tag, 1'b0, 2'b00, 20'h0, 16'h0, s, c, g, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        rst_n = 1'b0; hwrst_n = 1'b1; req_valid = 0; req_op = 0; req_addr = 0;
        erase_mask = 0; prot_set = 0; prot_clr = 0; prot_grp = 0; temp_unprot = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset grant", {31'd0, grant}, 32'd0);
        check("R10 reset deny", {31'd0, deny}, 32'd0);
        check("R10 reset idx", {28'd0, blk_idx}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        req("R4 prog blk6 open", 2'b00, 4'd6, 16'h0, 1'b0);
        cmd("R2 set grp3", 1'b1, 1'b0, 3'd3);
        req("R3 prog blk6 prot", 2'b00, 4'd6, 16'h0, 1'b0);
        req("R2 erase blk7 prot", 2'b01, 4'd7, 16'h0, 1'b0);
        req("R2 prog blk8 open", 2'b00, 4'd8, 16'h0, 1'b0);
        req("R2 prog blk5 open", 2'b00, 4'd5, 16'h0, 1'b0);
        req("R5 temp blk6", 2'b00, 4'd6, 16'h0, 1'b1);
        req("R5 temp blk7", 2'b01, 4'd7, 16'h0, 1'b1);
        step("R7 idle", 1'b0, 2'b00, 20'h70000, 16'h0, 0, 0, 0, 1'b1, 1'b1);
        req("R6 after temp blk6", 2'b00, 4'd6, 16'h0, 1'b0);
        step("R10 hwrst drop", 1'b1, 2'b00, 20'h20000, 16'h0, 0, 0, 0, 1'b0, 1'b0);
        req("R10 hwrst keeps bits", 2'b00, 4'd7, 16'h0, 1'b0);
        req("R8 multi mixed", 2'b10, 4'd0, 16'h01F0, 1'b0);
        req("R8 multi empty", 2'b11, 4'd0, 16'h0000, 1'b0);
        req("R8 multi temp", 2'b10, 4'd0, 16'hFFFF, 1'b1);
        cmd("R9 set+clr grp0", 1'b1, 1'b1, 3'd0);
        req("R9 blk1 protected", 2'b00, 4'd1, 16'h0, 1'b0);
        step("R9 clr same cycle as req", 1'b1, 2'b00, 20'h10000, 16'h0, 0, 1, 3'd0, 1'b0, 1'b1);
        req("R9 blk0 now open", 2'b00, 4'd0, 16'h0, 1'b0);
        cmd("R2 clr grp3", 1'b0, 1'b1, 3'd3);
        req("R4 blk7 open again", 2'b01, 4'd7, 16'h0, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom();
            step("R1 R3 R4 R5 R8 R9 random", r[0] | r[1], r[3:2], {r[7:4], r[23:8]},
                 $urandom(), r[24] & r[25], r[26] & r[27], r[30:28],
                 (r[31] & r[9]), ~(r[10] & r[11] & r[12]));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule